// File: doc/BRIEF.md
# Four-Bit Pipelined Load-Store Core

This block is a very small processor core. It works on 4-bit data, keeps four general registers, and runs a fixed program of sixteen 9-bit instructions. The program is held in an internal ROM, and its contents are set through a top-level parameter. The core recognises five operations: register copy, load of a constant, addition, multiplication and an idle slot. It has no data memory and no branches. The program counter advances on every clock and wraps around, so the program repeats for as long as the core runs.

Each instruction passes through five stages: fetch, decode, register read, ALU and write-back. The program counter is decoded into a one-hot row select for the ROM. Decode turns the register fields into one-hot register word lines. The register-read stage takes the results of the two older instructions that are still in the ALU and write-back stages and forwards them, so dependent instructions can follow each other with no stall.

The only output is a debug port. It shows every register-file write as an enable, a register index and a data value. An integrator embeds the core, loads a program through the parameter, and watches the debug port.

Top module: `nibble_core`

## Requirements
- R1: While `rst_n` is low, and for the first three rising edges after it is released, `dbg_wr_en` is 0. Reset clears the program counter, all four registers and every pipeline-valid bit.
- R2: An instruction word is laid out as follows. Bits [8:6] are the opcode: 000 idle, 001 copy, 010 load constant, 011 add, 100 multiply. Bits [5:4] hold the destination register index. Bits [3:2] hold source A and bits [1:0] hold source B. For load constant, bits [3:0] hold the constant. `dbg_wr_idx` reports the destination index in binary.
- R3: Copy writes the value of source A into the destination. Bits [1:0] have no effect.
- R4: Load constant writes bits [3:0] unchanged into the destination.
- R5: Add writes (A + B) mod 16.
- R6: Multiply writes (A × B) mod 16.
- R7: Idle (000) and the unused opcodes 101, 110 and 111 produce no register write, whatever the other bits hold.
- R8: Counting from the first rising edge after reset release as edge 1, the write of the n-th fetched instruction (n from 0) is shown on the debug port between edges n+4 and n+5. The register takes the new value at edge n+5.
- R9: An instruction that reads a register written by one of the two instructions just before it sees the new value, with no stall.
- R10: The program counter steps by one on every edge. After row 15 it wraps to row 0, so the program repeats in order.
- R11: The ROM row select has exactly one bit set outside reset. The register write word line has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_wr_en | output | 1 | A register-file write happens in this cycle |
| dbg_wr_idx | output | 2 | Index of the register being written |
| dbg_wr_data | output | 4 | Value being written |

## Verification
The bench builds the core with its default widths (4-bit data, four registers, a 16-row ROM) and loads a sixteen-row program through the parameter. The program mixes all five valid opcodes and two unused ones. It includes chains where each instruction uses the result of the one before, or the one two before, and so it reaches both forwarding paths. Rows that copy a register onto itself expose register contents on the debug port. Running the program through many wraps carries changing values into the add and multiply operands, so the arithmetic sees a wide spread of operand pairs rather than one fixed set. A reset in the middle of the run, followed by a second run, checks that all state is cleared.

// File: rtl/nibble_pkg.sv
package nibble_pkg;
  localparam int DW   = 4;
  localparam int IW   = 9;
  localparam int PCW  = 4;
  localparam int ROWS = 1 << PCW;
  localparam int NREG = 4;
  localparam int RIW  = $clog2(NREG);
  localparam int OPW  = 3;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 3'd0,
    OP_MOV = 3'd1,
    OP_MVI = 3'd2,
    OP_ADD = 3'd3,
    OP_MUL = 3'd4
  } op_e;

  typedef struct packed {
    logic            valid;
    logic            we;
    logic [OPW-1:0]  op;
    logic [NREG-1:0] dst_wl;
    logic [NREG-1:0] sa_wl;
    logic [NREG-1:0] sb_wl;
    logic [DW-1:0]   imm;
  } dec_t;

  function automatic logic [DW-1:0] nib_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] nib_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a * b;
  endfunction

  function automatic logic [NREG-1:0] idx_to_wl(input logic [RIW-1:0] idx);
    logic [NREG-1:0] wl;
    wl = '0;
    wl[idx] = 1'b1;
    return wl;
  endfunction

  function automatic logic [RIW-1:0] wl_to_idx(input logic [NREG-1:0] wl);
    logic [RIW-1:0] idx;
    idx = '0;
    for (int r = 0; r < NREG; r++) begin
      if (wl[r]) idx = idx | RIW'(r);
    end
    return idx;
  endfunction

  function automatic logic op_writes(input logic [OPW-1:0] op);
    return (op == OP_MOV) || (op == OP_MVI) || (op == OP_ADD) || (op == OP_MUL);
  endfunction
endpackage

// File: rtl/nibble_fetch.sv
module nibble_fetch
  import nibble_pkg::*;
#(
  parameter logic [ROWS*IW-1:0] PROGRAM = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PCW-1:0]  pc_o,
  output logic [ROWS-1:0] rom_wl_o,
  output logic [IW-1:0]   instr_o
);
  logic [PCW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_q + PCW'(1);
  end

  // one-hot word line per ROM row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rom_wl_o[r] = (pc_q == PCW'(r));
  end

  always_comb begin
    instr_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rom_wl_o[r]) instr_o = instr_o | PROGRAM[r*IW +: IW];
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/nibble_decode.sv
module nibble_decode
  import nibble_pkg::*;
(
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  logic [OPW-1:0] op;
  assign op = instr_i[IW-1 -: OPW];

  always_comb begin
    dec_o.valid  = valid_i;
    dec_o.op     = op;
    dec_o.we     = valid_i && op_writes(op);
    dec_o.dst_wl = idx_to_wl(instr_i[5:4]);
    dec_o.sa_wl  = idx_to_wl(instr_i[3:2]);
    dec_o.sb_wl  = idx_to_wl(instr_i[1:0]);
    dec_o.imm    = instr_i[DW-1:0];
  end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibble_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [DW-1:0]  imm_i,
  output logic [DW-1:0]  res_o
);
  always_comb begin
    case (op_i)
      OP_MOV:  res_o = a_i;
      OP_MVI:  res_o = imm_i;
      OP_ADD:  res_o = nib_add(a_i, b_i);
      OP_MUL:  res_o = nib_mul(a_i, b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/nibble_core.sv
module nibble_core
  import nibble_pkg::*;
#(
  parameter logic [ROWS*IW-1:0] PROGRAM = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           dbg_wr_en,
  output logic [RIW-1:0] dbg_wr_idx,
  output logic [DW-1:0]  dbg_wr_data
);
  // fetch
  logic [PCW-1:0]  pc;
  logic [ROWS-1:0] rom_wl;
  logic [IW-1:0]   rom_data;
  logic            if_valid;
  logic [IW-1:0]   if_instr;

  nibble_fetch #(.PROGRAM(PROGRAM)) u_fetch (
    .clk(clk), .rst_n(rst_n), .pc_o(pc), .rom_wl_o(rom_wl), .instr_o(rom_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_valid <= 1'b0;
      if_instr <= '0;
    end else begin
      if_valid <= 1'b1;
      if_instr <= rom_data;
    end
  end

  // decode
  dec_t id_dec;
  dec_t rr_dec;

  nibble_decode u_decode (.valid_i(if_valid), .instr_i(if_instr), .dec_o(id_dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_dec <= '0;
    else        rr_dec <= id_dec;
  end

  // register file and read stage with forwarding
  logic [DW-1:0]   rf [NREG];
  logic [DW-1:0]   rf_a, rf_b, opnd_a, opnd_b;
  logic            ex_valid, ex_we;
  logic [OPW-1:0]  ex_op;
  logic [NREG-1:0] ex_dst_wl;
  logic [DW-1:0]   ex_a, ex_b, ex_imm, alu_res;
  logic            wb_we;
  logic [NREG-1:0] wb_wl;
  logic [DW-1:0]   wb_data;
  logic            fwd_ex_a, fwd_ex_b, fwd_wb_a, fwd_wb_b;

  always_comb begin
    rf_a = '0;
    rf_b = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rr_dec.sa_wl[r]) rf_a = rf_a | rf[r];
      if (rr_dec.sb_wl[r]) rf_b = rf_b | rf[r];
    end
  end

  assign fwd_ex_a = ex_we && |(ex_dst_wl & rr_dec.sa_wl);
  assign fwd_ex_b = ex_we && |(ex_dst_wl & rr_dec.sb_wl);
  assign fwd_wb_a = wb_we && |(wb_wl & rr_dec.sa_wl);
  assign fwd_wb_b = wb_we && |(wb_wl & rr_dec.sb_wl);

  assign opnd_a = fwd_ex_a ? alu_res : (fwd_wb_a ? wb_data : rf_a);
  assign opnd_b = fwd_ex_b ? alu_res : (fwd_wb_b ? wb_data : rf_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid  <= 1'b0;
      ex_we     <= 1'b0;
      ex_op     <= '0;
      ex_dst_wl <= '0;
      ex_a      <= '0;
      ex_b      <= '0;
      ex_imm    <= '0;
    end else begin
      ex_valid  <= rr_dec.valid;
      ex_we     <= rr_dec.we;
      ex_op     <= rr_dec.op;
      ex_dst_wl <= rr_dec.dst_wl;
      ex_a      <= opnd_a;
      ex_b      <= opnd_b;
      ex_imm    <= rr_dec.imm;
    end
  end

  // ALU
  nibble_alu u_alu (.op_i(ex_op), .a_i(ex_a), .b_i(ex_b), .imm_i(ex_imm), .res_o(alu_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_we   <= 1'b0;
      wb_wl   <= '0;
      wb_data <= '0;
    end else begin
      wb_we   <= ex_we;
      wb_wl   <= ex_we ? ex_dst_wl : '0;
      wb_data <= alu_res;
    end
  end

  // write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wb_we && wb_wl[r]) rf[r] <= wb_data;
      end
    end
  end

  assign dbg_wr_en   = wb_we;
  assign dbg_wr_idx  = wl_to_idx(wb_wl);
  assign dbg_wr_data = wb_data;
endmodule

// File: rtl/nibble_core_chk.sv
module nibble_core_chk
  import nibble_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [PCW-1:0]  pc,
  input logic [ROWS-1:0] rom_wl,
  input logic [NREG-1:0] wb_wl,
  input logic            ex_valid,
  input logic [OPW-1:0]  ex_op,
  input logic [DW-1:0]   ex_a,
  input logic [DW-1:0]   ex_b,
  input logic            dbg_wr_en,
  input logic [DW-1:0]   dbg_wr_data
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !dbg_wr_en);

  assert_wr_has_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_en |-> ($countones(wb_wl) == 1));

  assert_add_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == OP_ADD) |=> (dbg_wr_en && dbg_wr_data == ($past(ex_a) + $past(ex_b))));

  assert_mul_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == OP_MUL) |=> (dbg_wr_en && dbg_wr_data == ($past(ex_a) * $past(ex_b))));

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op != OP_MOV && ex_op != OP_MVI && ex_op != OP_ADD && ex_op != OP_MUL)
      |=> !dbg_wr_en);

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pc == $past(pc) + PCW'(1)));

  assert_rom_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rom_wl) == 1);

  assert_wr_line_onehot0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_wl));
endmodule

bind nibble_core nibble_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .rom_wl(rom_wl), .wb_wl(wb_wl),
  .ex_valid(ex_valid), .ex_op(ex_op), .ex_a(ex_a), .ex_b(ex_b),
  .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data)
);

// File: tb/nibble_core_bench.sv
module nibble_core_bench;
  localparam logic [16*9-1:0] PROG = {
    9'b001_11_11_11,  // 15 copy r3<-r3
    9'b001_01_01_01,  // 14 copy r1<-r1
    9'b001_00_00_00,  // 13 copy r0<-r0
    9'b011_01_01_00,  // 12 r1 = r1 + r0
    9'b101_10_1010,   // 11 unused opcode
    9'b100_00_01_10,  // 10 r0 = r1 * r2
    9'b011_11_11_11,  //  9 r3 = r3 + r3
    9'b111_01_0101,   //  8 unused opcode
    9'b001_10_11_10,  //  7 copy r2<-r3, low field junk
    9'b100_01_00_00,  //  6 r1 = r0 * r0
    9'b000_11_1111,   //  5 idle with junk fields
    9'b011_00_11_00,  //  4 r0 = r3 + r0
    9'b100_11_10_01,  //  3 r3 = r2 * r1
    9'b011_10_00_01,  //  2 r2 = r0 + r1
    9'b010_01_0101,   //  1 r1 = 5
    9'b010_00_0011    //  0 r0 = 3
  };

  logic       clk;
  logic       rst_n;
  logic       dbg_wr_en;
  logic [1:0] dbg_wr_idx;
  logic [3:0] dbg_wr_data;

  int tests = 0;
  int fails = 0;
  int regs [4];

  nibble_core #(.PROGRAM(PROG)) u_nibble_core (
    .clk(clk), .rst_n(rst_n), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_phase(input int cycles);
    int last1, last2;
    last1 = -1;
    last2 = -1;
    for (int k = 0; k < 4; k++) regs[k] = 0;
    for (int n = 1; n <= cycles; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n < 4) begin
        check("R1 pipeline empty after reset", int'(dbg_wr_en), 0);
      end else begin
        int j, row, op, d, a, b, imm, ev, ed;
        bit we, dep;
        string tag;
        logic [8:0] ins;
        j = n - 4;
        row = j % 16;
        ins = PROG[row*9 +: 9];
        op = ins[8:6]; d = ins[5:4]; a = ins[3:2]; b = ins[1:0]; imm = ins[3:0];
        we = 1'b1;
        ev = 0;
        case (op)
          1: begin ev = regs[a]; tag = "R3 copy"; end
          2: begin ev = imm; tag = "R4 load constant"; end
          3: begin ev = (regs[a] + regs[b]) % 16; tag = "R5 add"; end
          4: begin ev = (regs[a] * regs[b]) % 16; tag = "R6 multiply"; end
          default: begin we = 1'b0; tag = "R7 no write"; end
        endcase
        dep = we && op != 2 && (a == last1 || a == last2 ||
              (op >= 3 && (b == last1 || b == last2)));
        if (dep) tag = {tag, " R9 forwarded"};
        if (j >= 16 && row == 0) tag = {tag, " R10 after wrap"};
        check({"R8 write enable ", tag}, int'(dbg_wr_en), int'(we));
        if (we) begin
          check({"R2 R11 index ", tag}, int'(dbg_wr_idx), d);
          check({"data ", tag}, int'(dbg_wr_data), ev);
          regs[d] = ev;
        end
        last2 = last1;
        ed = we ? d : -1;
        last1 = ed;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 quiet during reset", int'(dbg_wr_en), 0);
    rst_n = 1'b1;
    run_phase(16 * 12 + 4);
    // reset in mid run, then start over
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset clears write stage", int'(dbg_wr_en), 0);
    repeat (2) @(negedge clk);
    check("R1 quiet while held", int'(dbg_wr_en), 0);
    rst_n = 1'b1;
    run_phase(16 * 3 + 6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule